// File: doc/BRIEF.md
# Audio Device Status and Event Notification Registers

This block is the register file through which a host controls and observes an audio interface device. A host reaches it through quadlet reads and writes and through 64-bit compare-swap accesses. It holds a claim register that records the host owning the device and the address where that host wants event messages sent. It also holds the sample clock selection, the streaming enable, a live clock status word and an extended status word. The extended status word reports the lock state of eleven clock sources and keeps a sticky slip flag for each of them.

The block watches its event sources: configuration changes in the receive and transmit paths, changes in the lock of the current clock source, changes in the lock of any source, and completed clock-select writes. In every cycle that has at least one event, the event register is replaced by the word of new event bits. When an owner is registered, the same word is offered on a valid/ready output together with the owner's 64-bit address, so that a transaction layer can deliver it. A bus-reset input releases the owner claim and stops streaming. Lock, slip, rate and configuration-change inputs come from the surrounding clock recovery and stream logic.

Byte offsets: 0x00 owner bits 63:32 (also the compare-swap target), 0x04 owner bits 31:0, 0x08 event word, 0x0C clock select, 0x10 streaming enable, 0x14 clock status, 0x18 extended status. `req_op` encodes 0 read, 1 write, 2 compare-swap. Every request gives a response one cycle later on `rsp_valid`/`rsp_data`.

Top module: `audio_stat_regs`

## Requirements
- R1: After `rst` the owner reads 0xFFFF0000 at 0x00 and 0x00000000 at 0x04, the event word reads 0, clock select reads 0x0000020C, enable reads 0, no slip flag is set, and `ntf_valid` and `stream_en` are low.
- R2: A compare-swap to offset 0x00 returns the previous 64-bit owner value in `rsp_data` and stores `req_wdata` only when `req_cmp` equals the current owner; a mismatch leaves the owner unchanged.
- R3: A cycle with `bus_reset` high sets the owner to 0xFFFF_0000_0000_0000 and clears the enable bit; bus reset wins over a compare-swap in the same cycle.
- R4: In a cycle with events, the event word becomes exactly the new bits, encoded 0x01 receive configuration change, 0x02 transmit configuration change, 0x10 current-source lock change, 0x20 clock select accepted, 0x40 lock change of any source; earlier bits are dropped. Without events it holds.
- R5: An event cycle with an owner other than the no-owner value raises `ntf_valid` at the next edge, with `ntf_addr` equal to the owner and `ntf_data` equal to the event word. It stays high until a cycle with `ntf_ready` high, and a later event replaces the offered word. Nothing is offered while the owner holds the no-owner value.
- R6: Extended status bits 10:0 read the live `src_lock` inputs, and any change of `src_lock` from the previous cycle gives event 0x40.
- R7: A change of `cur_locked` from the previous cycle gives event 0x10.
- R8: Extended status bits 26:16 set when the matching `src_slip` bit is high and stay set. They clear only on a single-quadlet read of 0x18 (`req_block` low), which returns the value held before the clear. A block read does not clear them. A slip in the same cycle as a clearing read stays set. Slips give no event.
- R9: A write to 0x0C stores bits 15:0 (source in 7:0, rate code in 15:8), reads back with bits 31:16 zero, and gives event 0x20.
- R10: Clock status at 0x14 reads `cur_locked` in bit 0 and `cur_rate` in bits 15:8, all other bits zero.
- R11: Reads of unmapped offsets return zero. Writes to 0x00, 0x04, 0x08, 0x14 and 0x18 change nothing. A compare-swap to any offset other than 0x00 changes nothing and returns zero.
- R12: A write to 0x10 sets the enable to 1 when `req_wdata[31:0]` is non-zero and to 0 otherwise, shown on `stream_en` and in bit 0 of the read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Bus reset: releases owner, clears enable |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 compare-swap |
| req_block | input | 1 | Read is part of a block read |
| req_addr | input | 8 | Byte offset, quadlet aligned |
| req_wdata | input | 64 | Write data (bits 31:0) or swap value |
| req_cmp | input | 64 | Compare value for compare-swap |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_data | output | 64 | Read data or old owner value |
| src_lock | input | 11 | Live lock state per clock source |
| src_slip | input | 11 | Slip report per clock source |
| cur_locked | input | 1 | Current source locked |
| cur_rate | input | 8 | Nominal rate code of current source |
| rx_cfg_chg | input | 1 | Receive configuration changed pulse |
| tx_cfg_chg | input | 1 | Transmit configuration changed pulse |
| stream_en | output | 1 | Streaming enable |
| ntf_valid | output | 1 | Notification offered |
| ntf_ready | input | 1 | Notification taken |
| ntf_addr | output | 64 | Destination address (owner) |
| ntf_data | output | 32 | Event word to deliver |

## Verification
The assertions check several rules on every cycle. The owner only changes through a compare-swap or a bus reset, and a bus reset always leaves the no-owner value and a cleared enable. An offered notification holds until it is taken and never targets the no-owner address. Slip flags never drop without a clearing read, and the event word always equals the last event set. Other results need the bench's scenarios and its reference model: the old-value return of compare-swap, the exact bit layouts of the read words, replacement of a pending notification by a later event, block versus single reads of the slip flags, and the ignored writes.

// File: rtl/asr_pkg.sv
package asr_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned SRC_N  = 11;
    localparam int unsigned EVT_W  = 32;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_CSWAP = 2'd2
    } op_e;

    localparam logic [63:0] OWNER_NONE = 64'hFFFF_0000_0000_0000;

    localparam logic [ADDR_W-1:0] OFS_OWN_HI  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_OWN_LO  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_EVENT   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CLKSEL  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_ENABLE  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CLKSTAT = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_EXTSTAT = 8'h18;

    localparam logic [EVT_W-1:0] EV_RX_CFG  = 32'h0000_0001;
    localparam logic [EVT_W-1:0] EV_TX_CFG  = 32'h0000_0002;
    localparam logic [EVT_W-1:0] EV_CUR_LCK = 32'h0000_0010;
    localparam logic [EVT_W-1:0] EV_CLK_ACC = 32'h0000_0020;
    localparam logic [EVT_W-1:0] EV_ANY_LCK = 32'h0000_0040;

    typedef struct packed {
        logic [7:0] rate;
        logic [7:0] src;
    } clksel_t;

    localparam clksel_t CLKSEL_RESET = '{rate: 8'h02, src: 8'h0C};

    function automatic logic [31:0] ext_word(input logic [SRC_N-1:0] slip,
                                             input logic [SRC_N-1:0] lock);
        logic [31:0] w;
        w = '0;
        w[SRC_N-1:0]       = lock;
        w[16+SRC_N-1:16]   = slip;
        return w;
    endfunction

    function automatic logic [31:0] stat_word(input logic [7:0] rate,
                                              input logic locked);
        return {16'h0000, rate, 7'b0, locked};
    endfunction

endpackage

// File: rtl/asr_owner.sv
module asr_owner
    import asr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_reset,
    input  logic        cas_en,
    input  logic [63:0] cas_cmp,
    input  logic [63:0] cas_new,
    output logic [63:0] owner
);

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            owner <= OWNER_NONE;
        end else if (cas_en && (cas_cmp == owner)) begin
            owner <= cas_new;
        end
    end

    // R3: bus reset always leaves the no-owner value
    p_busreset_owner_r3: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (owner == OWNER_NONE));

    // R2: without a compare-swap or bus reset the owner holds
    p_owner_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!cas_en && !bus_reset) |=> $stable(owner));

    // R2: a mismatching compare leaves the owner unchanged
    p_cas_miss_r2: assert property (@(posedge clk) disable iff (rst)
        (cas_en && !bus_reset && (cas_cmp != owner)) |=> $stable(owner));

endmodule

// File: rtl/asr_lockstat.sv
module asr_lockstat
    import asr_pkg::*;
#(
    parameter int unsigned N = SRC_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src_lock,
    input  logic [N-1:0] src_slip,
    input  logic         cur_locked,
    input  logic         clr_slip,
    output logic         lock_chg,
    output logic         cur_chg,
    output logic [N-1:0] slip_q
);

    logic [N-1:0] lock_prev;
    logic         cur_prev;

    always_ff @(posedge clk) begin
        lock_prev <= src_lock;
        cur_prev  <= cur_locked;
    end

    assign lock_chg = !rst && (src_lock != lock_prev);
    assign cur_chg  = !rst && (cur_locked != cur_prev);

    for (genvar i = 0; i < N; i++) begin : g_slip
        always_ff @(posedge clk) begin
            if (rst) begin
                slip_q[i] <= 1'b0;
            end else if (src_slip[i]) begin
                slip_q[i] <= 1'b1;
            end else if (clr_slip) begin
                slip_q[i] <= 1'b0;
            end
        end
    end

    // R8: flags never drop without a clearing read
    p_slip_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !clr_slip |=> ((slip_q & $past(slip_q)) == $past(slip_q)));

    // R8: a reported slip is always captured
    p_slip_set_r8: assert property (@(posedge clk) disable iff (rst)
        (|src_slip) |=> ((slip_q & $past(src_slip)) == $past(src_slip)));

endmodule

// File: rtl/asr_notify.sv
module asr_notify
    import asr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] evt,
    input  logic [63:0]      owner,
    input  logic             ntf_ready,
    output logic [EVT_W-1:0] event_q,
    output logic             ntf_valid,
    output logic [63:0]      ntf_addr,
    output logic [EVT_W-1:0] ntf_data
);

    logic has_evt;
    logic owned;

    assign has_evt = |evt;
    assign owned   = (owner != OWNER_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            event_q   <= '0;
            ntf_valid <= 1'b0;
            ntf_addr  <= '0;
            ntf_data  <= '0;
        end else begin
            if (has_evt) begin
                event_q <= evt;
            end
            if (has_evt && owned) begin
                ntf_valid <= 1'b1;
                ntf_addr  <= owner;
                ntf_data  <= evt;
            end else if (ntf_ready) begin
                ntf_valid <= 1'b0;
            end
        end
    end

    // R4: the event word is replaced by exactly the new bits
    p_evt_replace_r4: assert property (@(posedge clk) disable iff (rst)
        has_evt |=> (event_q == $past(evt)));

    // R4: without events the word holds
    p_evt_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !has_evt |=> $stable(event_q));

    // R5: an untaken offer stays up with its payload
    p_ntf_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (ntf_valid && !ntf_ready && !has_evt) |=> (ntf_valid && $stable(ntf_data) && $stable(ntf_addr)));

    // R5: no offer targets the no-owner address
    p_ntf_owner_r5: assert property (@(posedge clk) disable iff (rst)
        ntf_valid |-> (ntf_addr != OWNER_NONE));

endmodule

// File: rtl/audio_stat_regs.sv
module audio_stat_regs
    import asr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_reset,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              req_block,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    input  logic [63:0]       req_cmp,
    output logic              rsp_valid,
    output logic [63:0]       rsp_data,
    input  logic [SRC_N-1:0]  src_lock,
    input  logic [SRC_N-1:0]  src_slip,
    input  logic              cur_locked,
    input  logic [7:0]        cur_rate,
    input  logic              rx_cfg_chg,
    input  logic              tx_cfg_chg,
    output logic              stream_en,
    output logic              ntf_valid,
    input  logic              ntf_ready,
    output logic [63:0]       ntf_addr,
    output logic [EVT_W-1:0]  ntf_data
);

    op_e op;
    logic is_rd, is_wr, is_cs;
    logic cas_en, clksel_wr, enable_wr, slip_clr, mapped;
    logic [63:0] owner;
    logic [SRC_N-1:0] slip_q;
    logic lock_chg, cur_chg;
    logic [EVT_W-1:0] evt, event_q;
    clksel_t clksel_q;
    logic [31:0] rd_word;

    assign op        = op_e'(req_op);
    assign is_rd     = req_valid && (op == OP_READ);
    assign is_wr     = req_valid && (op == OP_WRITE);
    assign is_cs     = req_valid && (op == OP_CSWAP);
    assign cas_en    = is_cs && (req_addr == OFS_OWN_HI);
    assign clksel_wr = is_wr && (req_addr == OFS_CLKSEL);
    assign enable_wr = is_wr && (req_addr == OFS_ENABLE);
    assign slip_clr  = is_rd && !req_block && (req_addr == OFS_EXTSTAT);

    asr_owner u_owner (
        .clk       (clk),
        .rst       (rst),
        .bus_reset (bus_reset),
        .cas_en    (cas_en),
        .cas_cmp   (req_cmp),
        .cas_new   (req_wdata),
        .owner     (owner)
    );

    asr_lockstat #(.N(SRC_N)) u_lockstat (
        .clk        (clk),
        .rst        (rst),
        .src_lock   (src_lock),
        .src_slip   (src_slip),
        .cur_locked (cur_locked),
        .clr_slip   (slip_clr),
        .lock_chg   (lock_chg),
        .cur_chg    (cur_chg),
        .slip_q     (slip_q)
    );

    always_comb begin
        evt = '0;
        if (rx_cfg_chg) evt = evt | EV_RX_CFG;
        if (tx_cfg_chg) evt = evt | EV_TX_CFG;
        if (cur_chg)    evt = evt | EV_CUR_LCK;
        if (clksel_wr)  evt = evt | EV_CLK_ACC;
        if (lock_chg)   evt = evt | EV_ANY_LCK;
    end

    asr_notify u_notify (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .owner     (owner),
        .ntf_ready (ntf_ready),
        .event_q   (event_q),
        .ntf_valid (ntf_valid),
        .ntf_addr  (ntf_addr),
        .ntf_data  (ntf_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            clksel_q  <= CLKSEL_RESET;
            stream_en <= 1'b0;
        end else begin
            if (clksel_wr) begin
                clksel_q <= clksel_t'(req_wdata[15:0]);
            end
            if (bus_reset) begin
                stream_en <= 1'b0;
            end else if (enable_wr) begin
                stream_en <= |req_wdata[31:0];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        mapped  = 1'b1;
        case (req_addr)
            OFS_OWN_HI:  rd_word = owner[63:32];
            OFS_OWN_LO:  rd_word = owner[31:0];
            OFS_EVENT:   rd_word = event_q;
            OFS_CLKSEL:  rd_word = {16'h0000, clksel_q};
            OFS_ENABLE:  rd_word = {31'b0, stream_en};
            OFS_CLKSTAT: rd_word = stat_word(cur_rate, cur_locked);
            OFS_EXTSTAT: rd_word = ext_word(slip_q, src_lock);
            default:     mapped  = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (cas_en) begin
                rsp_data <= owner;
            end else if (is_rd) begin
                rsp_data <= {32'h0, rd_word};
            end else begin
                rsp_data <= '0;
            end
        end
    end

    // R11: unmapped reads answer zero
    p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
        (is_rd && !mapped) |=> (rsp_valid && (rsp_data == 64'h0)));

    // R3: bus reset stops streaming
    p_busreset_en_r3: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> !stream_en);

    // R2: compare-swap returns the owner as it was
    p_cas_old_r2: assert property (@(posedge clk) disable iff (rst)
        cas_en |=> (rsp_data == $past(owner)));

endmodule

// File: tb/test_audio_stat_regs.sv
module test_audio_stat_regs;
    import asr_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_reset = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic req_block = 1'b0;
    logic [7:0] req_addr = 8'h00;
    logic [63:0] req_wdata = '0;
    logic [63:0] req_cmp = '0;
    logic rsp_valid;
    logic [63:0] rsp_data;
    logic [10:0] src_lock = '0;
    logic [10:0] src_slip = '0;
    logic cur_locked = 1'b0;
    logic [7:0] cur_rate = 8'h02;
    logic rx_cfg_chg = 1'b0;
    logic tx_cfg_chg = 1'b0;
    logic stream_en;
    logic ntf_valid;
    logic ntf_ready = 1'b0;
    logic [63:0] ntf_addr;
    logic [31:0] ntf_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    audio_stat_regs i_audio_stat_regs (
        .clk(clk), .rst(rst), .bus_reset(bus_reset),
        .req_valid(req_valid), .req_op(req_op), .req_block(req_block),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_cmp(req_cmp),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .src_lock(src_lock), .src_slip(src_slip),
        .cur_locked(cur_locked), .cur_rate(cur_rate),
        .rx_cfg_chg(rx_cfg_chg), .tx_cfg_chg(tx_cfg_chg),
        .stream_en(stream_en), .ntf_valid(ntf_valid), .ntf_ready(ntf_ready),
        .ntf_addr(ntf_addr), .ntf_data(ntf_data)
    );

    // Behavioural reference model, advanced on each rising edge
    longint unsigned m_owner;
    int unsigned m_event, m_clksel, m_ndata;
    longint unsigned m_naddr, m_rsp;
    bit m_en, m_nv, m_rv, m_prev_cur;
    bit [10:0] m_slip, m_prev_lock;
    string m_rtag;

    function automatic int unsigned model_read(input int a);
        case (a)
            8'h00: return int'(m_owner >> 32);
            8'h04: return int'(m_owner & 64'hFFFF_FFFF);
            8'h08: return m_event;
            8'h0C: return m_clksel;
            8'h10: return {31'b0, m_en};
            8'h14: return (int'(cur_rate) << 8) | int'(cur_locked);
            8'h18: return (int'(m_slip) << 16) | int'(src_lock);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        int unsigned ev;
        longint unsigned own_before;
        if (rst) begin
            m_owner = 64'hFFFF_0000_0000_0000;
            m_event = 0; m_clksel = 32'h020C; m_en = 0;
            m_nv = 0; m_ndata = 0; m_naddr = 0; m_rv = 0; m_rsp = 0;
            m_slip = '0; m_prev_lock = src_lock; m_prev_cur = cur_locked;
        end else begin
            ev = 0;
            own_before = m_owner;
            m_rv = req_valid;
            m_rsp = 0;
            m_rtag = cur_tag;
            if (req_valid) begin
                if (req_op == 2'd0) begin
                    m_rsp = longint'(model_read(int'(req_addr)));
                    if (req_addr == 8'h18 && !req_block) m_slip = '0;
                end else if (req_op == 2'd1) begin
                    if (req_addr == 8'h0C) begin
                        m_clksel = req_wdata[15:0];
                        ev = ev | 32'h20;
                    end
                    if (req_addr == 8'h10) m_en = (req_wdata[31:0] != 0);
                end else if (req_op == 2'd2 && req_addr == 8'h00) begin
                    m_rsp = own_before;
                    if (req_cmp == own_before) m_owner = req_wdata;
                end
            end
            if (rx_cfg_chg) ev = ev | 32'h01;
            if (tx_cfg_chg) ev = ev | 32'h02;
            if (cur_locked != m_prev_cur) ev = ev | 32'h10;
            if (src_lock != m_prev_lock) ev = ev | 32'h40;
            m_prev_cur = cur_locked;
            m_prev_lock = src_lock;
            m_slip = m_slip | src_slip;
            if (bus_reset) begin
                m_owner = 64'hFFFF_0000_0000_0000;
                m_en = 0;
            end
            if (m_nv && ntf_ready) m_nv = 0;
            if (ev != 0) begin
                m_event = ev;
                if (own_before != 64'hFFFF_0000_0000_0000) begin
                    m_nv = 1; m_ndata = ev; m_naddr = own_before;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare against the model on every falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(stream_en == m_en, "R12", "stream_en", 64'(stream_en), 64'(m_en));
            check(ntf_valid == m_nv, "R5", "ntf_valid", 64'(ntf_valid), 64'(m_nv));
            if (m_nv) begin
                check(ntf_data == m_ndata, "R4", "ntf_data", 64'(ntf_data), 64'(m_ndata));
                check(ntf_addr == m_naddr, "R5", "ntf_addr", ntf_addr, m_naddr);
            end
            check(rsp_valid == m_rv, m_rtag, "rsp_valid", 64'(rsp_valid), 64'(m_rv));
            if (m_rv) check(rsp_data == m_rsp, m_rtag, "rsp_data", rsp_data, m_rsp);
        end
    end

    task automatic req(input logic [1:0] op, input logic [7:0] a, input bit blk,
                       input logic [63:0] wd, input logic [63:0] cmpv, input string tag);
        @(negedge clk);
        cur_tag = tag;
        req_valid = 1; req_op = op; req_addr = a; req_block = blk;
        req_wdata = wd; req_cmp = cmpv;
        @(negedge clk);
        req_valid = 0; req_block = 0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        req(2'd0, a, 1'b0, '0, '0, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        req(2'd1, a, 1'b0, {32'h0, d}, '0, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_cfg(input bit rx, input bit tx);
        @(negedge clk);
        rx_cfg_chg = rx; tx_cfg_chg = tx;
        @(negedge clk);
        rx_cfg_chg = 0; tx_cfg_chg = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state at the ports and in the registers
        check(!ntf_valid && !stream_en, "R1", "outputs after reset", 64'({ntf_valid, stream_en}), 0);
        rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h08, "R1");
        rd(8'h0C, "R1"); rd(8'h10, "R1"); rd(8'h18, "R1");
        // R12: enable on non-zero, off on zero
        wr(8'h10, 32'h0000_0100, "R12"); idle(1);
        check(stream_en == 1'b1, "R12", "enable set", 64'(stream_en), 1);
        wr(8'h10, 32'h0, "R12"); wr(8'h10, 32'h1, "R12"); rd(8'h10, "R12");
        // R5: no offer while unowned
        pulse_cfg(1, 0); idle(1);
        check(!ntf_valid, "R5", "no offer without owner", 64'(ntf_valid), 0);
        // R2: miss then hit
        req(2'd2, 8'h00, 0, 64'hFFC1_0000_1234_5678, 64'h0, "R2");
        rd(8'h00, "R2");
        req(2'd2, 8'h00, 0, 64'hFFC1_0000_1234_5678, 64'hFFFF_0000_0000_0000, "R2");
        rd(8'h00, "R2"); rd(8'h04, "R2");
        // R11: plain writes and swap elsewhere ignored
        wr(8'h00, 32'h1111_1111, "R11"); wr(8'h04, 32'h2222_2222, "R11");
        wr(8'h08, 32'h7F, "R11"); wr(8'h14, 32'hFFFF, "R11"); wr(8'h18, 32'hFFFF_FFFF, "R11");
        req(2'd2, 8'h04, 0, 64'h5, 64'h1234_5678, "R11");
        rd(8'h00, "R11"); rd(8'h04, "R11"); rd(8'h08, "R11"); rd(8'h40, "R11"); rd(8'h1C, "R11");
        // R5: offer held until taken, R4 overwrite
        pulse_cfg(1, 0); idle(3);
        check(ntf_valid && ntf_data == 32'h1, "R5", "offer held", 64'(ntf_data), 1);
        pulse_cfg(1, 1); idle(1);
        check(ntf_data == 32'h3, "R4", "replaced word", 64'(ntf_data), 3);
        rd(8'h08, "R4");
        ntf_ready = 1; idle(2); ntf_ready = 0;
        // R9: clock select accepted
        wr(8'h0C, 32'hABCD_0401, "R9"); rd(8'h0C, "R9"); rd(8'h08, "R9");
        ntf_ready = 1; idle(1); ntf_ready = 0;
        // R6 and R7
        @(negedge clk); src_lock = 11'h008;
        idle(1); rd(8'h08, "R6"); rd(8'h18, "R6");
        @(negedge clk); cur_locked = 1; cur_rate = 8'h04;
        idle(1); rd(8'h08, "R7"); rd(8'h14, "R10");
        @(negedge clk); cur_locked = 0; src_lock = 11'h401;
        idle(1); rd(8'h08, "R4");
        ntf_ready = 1; idle(2); ntf_ready = 0;
        // R8: slips sticky, block read keeps, single read clears
        @(negedge clk); src_slip = 11'h402;
        @(negedge clk); src_slip = '0;
        idle(1);
        check(!ntf_valid, "R8", "slip gives no offer", 64'(ntf_valid), 0);
        rd(8'h08, "R8");
        req(2'd0, 8'h18, 1'b1, '0, '0, "R8");
        rd(8'h18, "R8"); rd(8'h18, "R8");
        @(negedge clk);
        cur_tag = "R8"; req_valid = 1; req_op = 2'd0; req_addr = 8'h18; src_slip = 11'h010;
        @(negedge clk);
        req_valid = 0; src_slip = '0;
        rd(8'h18, "R8");
        // R3: bus reset wins over swap, then no offer
        @(negedge clk);
        cur_tag = "R3"; bus_reset = 1; req_valid = 1; req_op = 2'd2; req_addr = 8'h00;
        req_cmp = 64'hFFC1_0000_1234_5678; req_wdata = 64'h1;
        @(negedge clk);
        bus_reset = 0; req_valid = 0;
        rd(8'h00, "R3"); rd(8'h04, "R3");
        check(!stream_en, "R3", "enable cleared", 64'(stream_en), 0);
        pulse_cfg(0, 1); idle(2);
        check(!ntf_valid, "R3", "no offer after release", 64'(ntf_valid), 0);
        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        done = 1;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule